// File: doc/BRIEF.md
# Scan-Driven Bus Master Bridge

This block lets a debug host reach the system bus through a serial scan path. While the chain is selected, a 73-bit access frame is shifted in on the test clock, least significant bit first. The frame holds a target address, a direction flag, a data word and a check byte. At the update strobe the block checks the frame's length and its check byte. A frame that passes both checks is handed to the bus clock domain, which runs exactly one single-word cycle on a Wishbone master port. A frame that fails either check raises the `crc_err_o` flag and starts nothing.

Both directions go through the same scan. The capture strobe of every scan loads a 33-bit readback word, and the shift that follows sends it out on `tdo_o` while the next frame comes in. The readback word holds the data of the last completed read, or the error status of the last bus cycle. Read results therefore come back one scan later than the frame that asked for them.

The test side has no back-pressure. After an accepted update the host must wait a few test clocks before the next update. On the bus side the only flow control is the slave's acknowledge or error response.

Top module: `scan_bus_bridge`

## Requirements
- R1: Frame bit k is the k-th bit shifted in. Bits 0 to 31 are the address and bit 32 is the direction (1 = write, 0 = read). Bits 33 to 64 are the data word and bits 72 down to 65 are the received check byte, with bit 65 as its bit 0.
- R2: The check byte is CRC-8 with polynomial x^8+x^2+x+1 and initial value 0. It is computed serially over frame bits 0 to 64 in shift order, with each bit XORed into the feedback taken from state bit 7.
- R3: At update a frame is accepted only if exactly 73 shifts occurred since capture and the received byte equals the computed one. Otherwise `crc_err_o` becomes 1 and no bus cycle follows. An accepted frame clears `crc_err_o`. After reset `crc_err_o`, `wb_cyc_o` and `tdo_o` are 0.
- R4: An accepted frame produces exactly one bus cycle. `wb_cyc_o` and `wb_stb_o` rise at the third rising bus-clock edge after the test-clock edge that sampled the update strobe.
- R5: During a cycle, address, write enable and outgoing data stay stable, `wb_sel_o` is 4'b1111, `wb_cab_o` is 0 and cyc equals stb. The cycle ends at the first bus edge where `wb_ack_i` or `wb_err_i` is high.
- R6: In a read frame the data field is ignored, and `wb_dat_o` is 0 throughout a read cycle.
- R7: A read ended by acknowledge stores `wb_dat_i`. At the next capture, `tdo_o` then shows those 32 bits LSB first, followed by a status bit of 0.
- R8: A cycle ended by error, including one where acknowledge is high in the same cycle, sets the status bit to 1 and zeroes the 32 readback data bits. The status bit clears when the next bus cycle starts.
- R9: A write ended by acknowledge leaves the stored read data unchanged.
- R10: While `chain_sel_i` is 0, the capture, shift and update strobes are ignored: no bus cycle starts and `crc_err_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| bus_clk_i | input | 1 | Bus clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, both domains |
| chain_sel_i | input | 1 | This chain is the selected scan data register |
| capture_i | input | 1 | Capture strobe (test clock) |
| shift_i | input | 1 | Shift strobe (test clock) |
| update_i | input | 1 | Update strobe (test clock) |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial readback out |
| crc_err_o | output | 1 | Last judged frame was rejected |
| wb_adr_o | output | 32 | Bus address |
| wb_dat_o | output | 32 | Bus write data |
| wb_dat_i | input | 32 | Bus read data |
| wb_sel_o | output | 4 | Byte select |
| wb_we_o | output | 1 | Write enable |
| wb_cyc_o | output | 1 | Cycle valid |
| wb_stb_o | output | 1 | Strobe |
| wb_cab_o | output | 1 | Burst hint, always 0 |
| wb_ack_i | input | 1 | Slave acknowledge |
| wb_err_i | input | 1 | Slave error |

## Verification
Two terminations can land on the same bus edge: the slave may raise acknowledge and error together. The bench provokes this with one read whose slave response drives both lines in the same cycle. It then expects the following scan to return a status bit of 1 with zero data. The next read, ended by acknowledge alone, must clear that status. A second overlap happens at every scan: the shift that returns the previous result also carries in the next frame. The bench judges each readback against the result its cycle model predicted, even when the frame being shifted in is rejected.

// File: rtl/sbb_pkg.sv
package sbb_pkg;

  // bus-side sequencer states
  typedef enum logic [0:0] {
    BUS_IDLE = 1'b0,
    BUS_BUSY = 1'b1
  } bus_state_e;

  // one direction flag sits between address and data
  localparam int unsigned DIR_BITS = 1;

  function automatic int unsigned frame_bits(input int unsigned aw,
                                             input int unsigned dw,
                                             input int unsigned cw);
    return aw + DIR_BITS + dw + cw;
  endfunction

endpackage

// File: rtl/sbb_crc_serial.sv
module sbb_crc_serial #(
  parameter int unsigned    W    = 8,
  parameter logic [W-1:0]   POLY = 8'h07
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_o
);

  logic [W-1:0] state_q;
  logic [W-1:0] state_d;
  logic         fb;

  assign fb = bit_i ^ state_q[W-1];

  // one Galois step per bit; each tap is a generated XOR
  for (genvar i = 0; i < W; i++) begin : g_tap
    if (i == 0) begin : g_low
      assign state_d[i] = POLY[i] & fb;
    end else begin : g_up
      assign state_d[i] = state_q[i-1] ^ (POLY[i] & fb);
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)   state_q <= '0;
    else if (clr_i) state_q <= '0;
    else if (en_i)  state_q <= state_d;
  end

  assign crc_o = state_q;

endmodule

// File: rtl/sbb_frame_rx.sv
module sbb_frame_rx #(
  parameter int unsigned         ADDR_W   = 32,
  parameter int unsigned         DATA_W   = 32,
  parameter int unsigned         CRC_W    = 8,
  parameter logic [CRC_W-1:0]    CRC_POLY = 8'h07
) (
  input  logic              tck_i,
  input  logic              rst_n_i,
  input  logic              sel_i,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              update_i,
  input  logic              tdi_i,
  output logic [ADDR_W-1:0] req_adr_o,
  output logic              req_we_o,
  output logic [DATA_W-1:0] req_dat_o,
  output logic              req_tog_o,
  output logic              crc_err_o
);

  localparam int unsigned FRAME_W = sbb_pkg::frame_bits(ADDR_W, DATA_W, CRC_W);
  localparam int unsigned DIR_POS = ADDR_W;
  localparam int unsigned DAT_LO  = ADDR_W + sbb_pkg::DIR_BITS;
  localparam int unsigned CRC_LO  = DAT_LO + DATA_W;
  localparam int unsigned CNT_MAX = FRAME_W + 1;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  logic [FRAME_W-1:0] frame_q;
  logic [CNT_W-1:0]   bit_cnt_q;
  logic [CRC_W-1:0]   calc_crc;
  logic [CRC_W-1:0]   rx_crc;
  logic               cap_en, sh_en, up_en, crc_en, frame_ok;

  assign cap_en = sel_i & capture_i;
  assign sh_en  = sel_i & shift_i;
  assign up_en  = sel_i & update_i;
  // only bits ahead of the check field enter the running CRC
  assign crc_en = sh_en && (bit_cnt_q < CNT_W'(CRC_LO));

  sbb_crc_serial #(
    .W    (CRC_W),
    .POLY (CRC_POLY)
  ) crc_i (
    .clk_i   (tck_i),
    .rst_n_i (rst_n_i),
    .clr_i   (cap_en),
    .en_i    (crc_en),
    .bit_i   (tdi_i),
    .crc_o   (calc_crc)
  );

  assign rx_crc   = frame_q[FRAME_W-1:CRC_LO];
  assign frame_ok = (bit_cnt_q == CNT_W'(FRAME_W)) && (rx_crc == calc_crc);

  // serial assembly: newest bit enters at the top, first bit ends at 0
  always_ff @(posedge tck_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      frame_q   <= '0;
      bit_cnt_q <= '0;
    end else if (cap_en) begin
      bit_cnt_q <= '0;
    end else if (sh_en) begin
      frame_q <= {tdi_i, frame_q[FRAME_W-1:1]};
      if (bit_cnt_q != CNT_W'(CNT_MAX)) bit_cnt_q <= bit_cnt_q + 1'b1;
    end
  end

  // judgement at update; accepted fields are held for the bus side
  always_ff @(posedge tck_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      req_adr_o <= '0;
      req_we_o  <= 1'b0;
      req_dat_o <= '0;
      req_tog_o <= 1'b0;
      crc_err_o <= 1'b0;
    end else if (up_en) begin
      if (frame_ok) begin
        req_adr_o <= frame_q[ADDR_W-1:0];
        req_we_o  <= frame_q[DIR_POS];
        req_dat_o <= frame_q[CRC_LO-1:DAT_LO];
        req_tog_o <= ~req_tog_o;
        crc_err_o <= 1'b0;
      end else begin
        crc_err_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sbb_toggle_sync.sv
module sbb_toggle_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic tog_i,
  output logic pulse_o
);

  // STAGES synchroniser flops plus one flop for the edge compare
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= {chain_q[STAGES-1:0], tog_i};
  end

  assign pulse_o = chain_q[STAGES] ^ chain_q[STAGES-1];

endmodule

// File: rtl/sbb_bus_master.sv
module sbb_bus_master #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_n_i,
  input  logic                start_i,
  input  logic [ADDR_W-1:0]   req_adr_i,
  input  logic                req_we_i,
  input  logic [DATA_W-1:0]   req_dat_i,
  output logic [ADDR_W-1:0]   wb_adr_o,
  output logic [DATA_W-1:0]   wb_dat_o,
  input  logic [DATA_W-1:0]   wb_dat_i,
  output logic [DATA_W/8-1:0] wb_sel_o,
  output logic                wb_we_o,
  output logic                wb_cyc_o,
  output logic                wb_stb_o,
  output logic                wb_cab_o,
  input  logic                wb_ack_i,
  input  logic                wb_err_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                berr_o
);

  sbb_pkg::bus_state_e state_q;

  // single full-width transfers only
  assign wb_sel_o = '1;
  assign wb_cab_o = 1'b0;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q  <= sbb_pkg::BUS_IDLE;
      wb_cyc_o <= 1'b0;
      wb_stb_o <= 1'b0;
      wb_adr_o <= '0;
      wb_we_o  <= 1'b0;
      wb_dat_o <= '0;
      rdata_o  <= '0;
      berr_o   <= 1'b0;
    end else begin
      unique case (state_q)
        sbb_pkg::BUS_IDLE: begin
          if (start_i) begin
            state_q  <= sbb_pkg::BUS_BUSY;
            wb_cyc_o <= 1'b1;
            wb_stb_o <= 1'b1;
            wb_adr_o <= req_adr_i;
            wb_we_o  <= req_we_i;
            wb_dat_o <= req_we_i ? req_dat_i : '0;
            berr_o   <= 1'b0;
          end
        end
        sbb_pkg::BUS_BUSY: begin
          if (wb_err_i) begin
            // error wins over a simultaneous acknowledge
            state_q  <= sbb_pkg::BUS_IDLE;
            wb_cyc_o <= 1'b0;
            wb_stb_o <= 1'b0;
            berr_o   <= 1'b1;
          end else if (wb_ack_i) begin
            state_q  <= sbb_pkg::BUS_IDLE;
            wb_cyc_o <= 1'b0;
            wb_stb_o <= 1'b0;
            if (!wb_we_o) rdata_o <= wb_dat_i;
          end
        end
        default: state_q <= sbb_pkg::BUS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sbb_readback.sv
module sbb_readback #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              tck_i,
  input  logic              rst_n_i,
  input  logic              sel_i,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              berr_i,
  output logic              tdo_o
);

  localparam int unsigned RB_W = DATA_W + 1;

  logic [RB_W-1:0] out_q;

  // bus-side result is quiet by the time the host captures
  always_ff @(posedge tck_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      out_q <= '0;
    end else if (sel_i & capture_i) begin
      out_q <= {berr_i, (berr_i ? {DATA_W{1'b0}} : rdata_i)};
    end else if (sel_i & shift_i) begin
      out_q <= {1'b0, out_q[RB_W-1:1]};
    end
  end

  assign tdo_o = out_q[0];

endmodule

// File: rtl/scan_bus_bridge.sv
module scan_bus_bridge #(
  parameter int unsigned      ADDR_W      = 32,
  parameter int unsigned      DATA_W      = 32,
  parameter int unsigned      CRC_W       = 8,
  parameter logic [CRC_W-1:0] CRC_POLY    = 8'h07,
  parameter int unsigned      SYNC_STAGES = 2
) (
  input  logic                tck_i,
  input  logic                bus_clk_i,
  input  logic                rst_n_i,
  input  logic                chain_sel_i,
  input  logic                capture_i,
  input  logic                shift_i,
  input  logic                update_i,
  input  logic                tdi_i,
  output logic                tdo_o,
  output logic                crc_err_o,
  output logic [ADDR_W-1:0]   wb_adr_o,
  output logic [DATA_W-1:0]   wb_dat_o,
  input  logic [DATA_W-1:0]   wb_dat_i,
  output logic [DATA_W/8-1:0] wb_sel_o,
  output logic                wb_we_o,
  output logic                wb_cyc_o,
  output logic                wb_stb_o,
  output logic                wb_cab_o,
  input  logic                wb_ack_i,
  input  logic                wb_err_i
);

  logic [ADDR_W-1:0] req_adr;
  logic              req_we;
  logic [DATA_W-1:0] req_dat;
  logic              req_tog;
  logic              start_pulse;
  logic [DATA_W-1:0] rd_data;
  logic              bus_err;

  sbb_frame_rx #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CRC_W    (CRC_W),
    .CRC_POLY (CRC_POLY)
  ) rx_i (
    .tck_i     (tck_i),
    .rst_n_i   (rst_n_i),
    .sel_i     (chain_sel_i),
    .capture_i (capture_i),
    .shift_i   (shift_i),
    .update_i  (update_i),
    .tdi_i     (tdi_i),
    .req_adr_o (req_adr),
    .req_we_o  (req_we),
    .req_dat_o (req_dat),
    .req_tog_o (req_tog),
    .crc_err_o (crc_err_o)
  );

  sbb_toggle_sync #(
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk_i   (bus_clk_i),
    .rst_n_i (rst_n_i),
    .tog_i   (req_tog),
    .pulse_o (start_pulse)
  );

  sbb_bus_master #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) bus_i (
    .clk_i     (bus_clk_i),
    .rst_n_i   (rst_n_i),
    .start_i   (start_pulse),
    .req_adr_i (req_adr),
    .req_we_i  (req_we),
    .req_dat_i (req_dat),
    .wb_adr_o  (wb_adr_o),
    .wb_dat_o  (wb_dat_o),
    .wb_dat_i  (wb_dat_i),
    .wb_sel_o  (wb_sel_o),
    .wb_we_o   (wb_we_o),
    .wb_cyc_o  (wb_cyc_o),
    .wb_stb_o  (wb_stb_o),
    .wb_cab_o  (wb_cab_o),
    .wb_ack_i  (wb_ack_i),
    .wb_err_i  (wb_err_i),
    .rdata_o   (rd_data),
    .berr_o    (bus_err)
  );

  sbb_readback #(
    .DATA_W (DATA_W)
  ) rb_i (
    .tck_i     (tck_i),
    .rst_n_i   (rst_n_i),
    .sel_i     (chain_sel_i),
    .capture_i (capture_i),
    .shift_i   (shift_i),
    .rdata_i   (rd_data),
    .berr_i    (bus_err),
    .tdo_o     (tdo_o)
  );

endmodule

// File: rtl/sbb_checker.sv
module sbb_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              tck_i,
  input logic              bus_clk_i,
  input logic              rst_n_i,
  input logic              chain_sel_i,
  input logic              update_i,
  input logic              req_tog,
  input logic              crc_err_o,
  input logic [ADDR_W-1:0] wb_adr_o,
  input logic [DATA_W-1:0] wb_dat_o,
  input logic              wb_we_o,
  input logic              wb_cyc_o,
  input logic              wb_stb_o,
  input logic              wb_ack_i,
  input logic              wb_err_i
);

  // R5: an open cycle keeps its request until terminated
  p_hold_request_r5: assert property (@(posedge bus_clk_i) disable iff (!rst_n_i)
    (wb_cyc_o && !wb_ack_i && !wb_err_i) |=>
      (wb_cyc_o && wb_stb_o && $stable(wb_adr_o) && $stable(wb_we_o) && $stable(wb_dat_o)));

  // R5: acknowledge or error closes the cycle on the next edge
  p_release_on_term_r5: assert property (@(posedge bus_clk_i) disable iff (!rst_n_i)
    (wb_cyc_o && (wb_ack_i || wb_err_i)) |=> (!wb_cyc_o && !wb_stb_o));

  // R6: a read never drives data
  p_read_quiet_r6: assert property (@(posedge bus_clk_i) disable iff (!rst_n_i)
    (wb_cyc_o && !wb_we_o) |-> (wb_dat_o == '0));

  // R3: each judged frame either launches a request or raises the flag
  p_one_outcome_r3: assert property (@(posedge tck_i) disable iff (!rst_n_i)
    (chain_sel_i && update_i) |=> ((req_tog != $past(req_tog)) != crc_err_o));

  // R10: no request leaves without a selected update
  p_no_stray_req_r10: assert property (@(posedge tck_i) disable iff (!rst_n_i)
    !(chain_sel_i && update_i) |=> $stable(req_tog));

endmodule

bind scan_bus_bridge sbb_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) chk_i (
  .tck_i       (tck_i),
  .bus_clk_i   (bus_clk_i),
  .rst_n_i     (rst_n_i),
  .chain_sel_i (chain_sel_i),
  .update_i    (update_i),
  .req_tog     (req_tog),
  .crc_err_o   (crc_err_o),
  .wb_adr_o    (wb_adr_o),
  .wb_dat_o    (wb_dat_o),
  .wb_we_o     (wb_we_o),
  .wb_cyc_o    (wb_cyc_o),
  .wb_stb_o    (wb_stb_o),
  .wb_ack_i    (wb_ack_i),
  .wb_err_i    (wb_err_i)
);

// File: tb/scan_bus_bridge_tb_top.sv
module scan_bus_bridge_tb_top;

  // time unit taken as 1 ns: bus clock 10 (100 MHz), test clock 40
  logic        tck = 1'b0, clk = 1'b0, rst_n = 1'b0;
  logic        sel = 1'b0, cap = 1'b0, sh = 1'b0, upd = 1'b0, tdi = 1'b0;
  logic        tdo, crc_err;
  logic [31:0] adr, dat_o, dat_i;
  logic [3:0]  bsel;
  logic        we, cyc, stb, cab;
  logic        ack = 1'b0, err = 1'b0;

  int nchk = 0, nerr = 0;

  scan_bus_bridge dut_i (
    .tck_i(tck), .bus_clk_i(clk), .rst_n_i(rst_n), .chain_sel_i(sel),
    .capture_i(cap), .shift_i(sh), .update_i(upd), .tdi_i(tdi), .tdo_o(tdo),
    .crc_err_o(crc_err), .wb_adr_o(adr), .wb_dat_o(dat_o), .wb_dat_i(dat_i),
    .wb_sel_o(bsel), .wb_we_o(we), .wb_cyc_o(cyc), .wb_stb_o(stb),
    .wb_cab_o(cab), .wb_ack_i(ack), .wb_err_i(err)
  );

  always #5 clk = ~clk;
  initial begin #2; forever #20 tck = ~tck; end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic logic [7:0] ref_crc(input logic [64:0] b);
    logic [7:0] c = 8'h00;
    for (int i = 0; i <= 64; i++) begin
      logic fb = b[i] ^ c[7];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  function automatic logic [79:0] mk_frame(input logic [31:0] a, input logic w, input logic [31:0] d);
    logic [64:0] body = {d, w, a};
    return {7'h0, ref_crc(body), body};
  endfunction

  int          m_wait = 0;
  logic        m_cyc = 0, m_we = 0, m_err = 0, m_crc_err = 0;
  logic [31:0] m_adr = 0, m_dat = 0, m_rdata = 0;
  logic [31:0] p_adr, p_dat;
  logic        p_we;

  // bus slave: answer after s_lat cycles with chosen response
  int          s_lat = 2, wcnt = 0;
  logic        s_ack = 1, s_err = 0;
  logic [31:0] s_rdata = 32'h0;

  always @(negedge clk) begin
    ack = 1'b0; err = 1'b0; dat_i = 32'h0;
    if (cyc) begin
      wcnt++;
      if (wcnt >= s_lat) begin ack = s_ack; err = s_err; dat_i = s_rdata; end
    end else wcnt = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cyc = 0; m_wait = 0; m_err = 0; m_rdata = 0;
    end else if (m_cyc) begin
      if (err) begin m_cyc = 0; m_err = 1; end
      else if (ack) begin m_cyc = 0; if (!m_we) m_rdata = dat_i; end
    end else if (m_wait > 0) begin
      m_wait--;
      if (m_wait == 0) begin
        m_cyc = 1; m_adr = p_adr; m_we = p_we; m_dat = p_dat; m_err = 0;
      end
    end
  end

  // per-cycle comparison of the bus port
  always @(negedge clk) begin
    if (rst_n) begin
      check(cyc == m_cyc && stb == m_cyc, "R4 cyc/stb", {cyc, stb}, {m_cyc, m_cyc});
      if (m_cyc) begin
        check(adr == m_adr, "R1 R5 address", adr, m_adr);
        check(we == m_we, "R1 R5 direction", we, m_we);
        check(dat_o == (m_we ? m_dat : 32'h0), "R6 R5 data", dat_o, m_we ? m_dat : 32'h0);
        check(bsel == 4'hf && cab == 1'b0, "R5 sel/cab", {bsel, cab}, {4'hf, 1'b0});
      end
    end
  end

  // ---------------- scan driver ----------------
  task automatic scan(input logic [79:0] fr, input int nbits, input logic s, input string rb_tag);
    logic [32:0] got = '0;
    logic [32:0] exp_rb;
    logic        ok;
    @(negedge tck);
    exp_rb = m_err ? {1'b1, 32'h0} : {1'b0, m_rdata};
    sel = s; cap = 1'b1;
    for (int k = 0; k < nbits; k++) begin
      @(negedge tck);
      cap = 1'b0; sh = 1'b1; tdi = fr[k];
      if (k < 33) got[k] = tdo;
    end
    @(negedge tck);
    sh = 1'b0; upd = 1'b1; tdi = 1'b0;
    ok = s && (nbits == 73) && (fr[72:65] == ref_crc(fr[64:0]));
    @(posedge tck);
    if (s) begin
      m_crc_err = !ok;
      if (ok) begin p_adr = fr[31:0]; p_we = fr[32]; p_dat = fr[64:33]; m_wait = 3; end
    end
    @(negedge tck);
    upd = 1'b0; sel = 1'b0;
    check(crc_err == m_crc_err, s ? "R3 R2 frame judgement" : "R10 flag kept", crc_err, m_crc_err);
    if (s && nbits >= 33) check(got == exp_rb, rb_tag, got, exp_rb);
    repeat (12) @(negedge tck);
  endtask

  logic [79:0] f;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge tck);
    check(crc_err == 1'b0 && cyc == 1'b0 && tdo == 1'b0, "R3 reset state", {crc_err, cyc, tdo}, 3'b000);

    s_lat = 2; s_ack = 1; s_err = 0; s_rdata = 32'h0;
    scan(mk_frame(32'h18273645, 1'b1, 32'hbeefbeef), 73, 1'b1, "R7 initial readback");

    s_lat = 3; s_rdata = 32'hbeefdead;
    scan(mk_frame(32'h87654321, 1'b0, 32'hffffffff), 73, 1'b1, "R9 readback after write");

    s_lat = 1;
    scan(mk_frame(32'h00000010, 1'b1, 32'h0000c0de), 73, 1'b1, "R7 read data");

    f = mk_frame(32'h00000020, 1'b1, 32'h12345678);
    f[70] = ~f[70];
    scan(f, 73, 1'b1, "R9 read data kept after write");

    scan({6'h0, 1'b0, mk_frame(32'h00000030, 1'b1, 32'h1)}, 74, 1'b1, "R9 readback on long frame");

    scan(mk_frame(32'h00000040, 1'b1, 32'h2), 73, 1'b0, "R10 deselected");

    s_lat = 2; s_ack = 0; s_err = 1;
    scan(mk_frame(32'h00000050, 1'b0, 32'h0), 73, 1'b1, "R9 readback before error");

    s_ack = 1; s_err = 1; s_rdata = 32'h55aa55aa;
    scan(mk_frame(32'h00000060, 1'b0, 32'h0), 73, 1'b1, "R8 error status");

    s_ack = 1; s_err = 0; s_rdata = 32'h13579bdf;
    scan(mk_frame(32'h00000070, 1'b0, 32'h0), 73, 1'b1, "R8 ack with error");

    scan(mk_frame(32'h00000080, 1'b1, 32'hfeedf00d), 73, 1'b1, "R8 status cleared");

    scan(mk_frame(32'h00000090, 1'b1, 32'h3), 72, 1'b1, "R9 readback on short frame");

    scan(mk_frame(32'h000000a0, 1'b0, 32'h0), 73, 1'b1, "R7 readback final");

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #1000000;
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule